// File: doc/BRIEF.md
# Ready-Stretched Two-Phase Bus Master

This block drives a simple parallel bus on behalf of a host. Each access runs in two bus clocks: an address phase and then a data phase. In the address phase the master raises the frame, the strobe for the access direction and the address. In the data phase it drops frame and strobes and keeps only the address, plus the write data for a write. A read returns the value found on the input data bus at the end of the data phase. The host learns that an access has finished from a one-clock done pulse.

A slow target can add wait states through an active-high ready input. The master samples ready on the falling clock edge. If ready is low, the phase in progress repeats on the next rising edge, and its outputs stay as they are. A configuration bit turns this stretching on. When the bit is clear the ready input has no effect and every access takes exactly two clocks. The bus clock is assumed free-running; the block does not gate it.

Top module: `rdyBusMaster`

## Requirements
- R1: `reqReady` is high exactly when the master is idle. A request (`reqValid` high while `reqReady` is high) is taken on that rising edge. A request presented while busy is ignored, and the bus outputs of the access in flight do not change.
- R2: In the address phase `busFrame` is high and `busAddr` equals the request address. `busRd` is high for a read (`reqWrite`=0) and `busWr` is high for a write (`reqWrite`=1). Only one strobe is high.
- R3: In the data phase `busFrame`, `busRd` and `busWr` are low, and `busAddr` still carries the request address.
- R4: `busRdy` is sampled on the falling clock edge. If stretching is enabled and the sample taken in the address phase is low, the address phase repeats with unchanged outputs.
- R5: If stretching is enabled and the falling-edge sample taken in the data phase is low, the data phase repeats with unchanged outputs.
- R6: For a read, `rdData` takes the value `busDin` had in the last data-phase cycle, which is the one whose ready sample was high. Values present in stalled cycles are not kept.
- R7: With `cfgRdyEn`=0, `busRdy` is ignored and an access holds one address-phase cycle and one data-phase cycle.
- R8: `busDoe` is high only during the address and data phases of a write, and then `busDout` equals the write data. It is low for reads and when idle.
- R9: `doneOut` is high for exactly one clock. That clock is the one right after the last data-phase cycle, and the master is idle then.
- R10: While reset (`rstN` low) is asserted, and after it is released, the master is idle. All strobes, `busDoe` and `doneOut` are low, and `busAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRdyEn | input | 1 | Enables stretching by the ready input |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| reqReady | output | 1 | Master idle, request can be taken |
| doneOut | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Last read result |
| busFrame | output | 1 | Frame, high in the address phase |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busAddr | output | ADDR_W | Address bus |
| busDout | output | DATA_W | Data bus output value |
| busDoe | output | 1 | Data bus output enable |
| busDin | input | DATA_W | Data bus input value |
| busRdy | input | 1 | Active-high target ready |

## Verification
If the phase register is wrong, the bus shows it in the same clock: frame appears where it should not, or the address drops out while the data phase is held, or `reqReady` rises while an access is still running. If a hold decision is wrong, the access comes out one or more clocks too long or too short. This shows directly in when `doneOut` rises. If the capture point is wrong, `rdData` holds a value from a stalled cycle; the bench drives such values so that it can tell them apart from the real data. The bench sweeps both directions, zero to three stall cycles in each phase, and both settings of the enable bit, so these errors show up in the first access that uses the faulty path.

// File: rtl/rdyBusPkg.sv
package rdyBusPkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } busPhase_t;

  typedef struct packed {
    logic loadReq;
    logic phaseAddr;
    logic phaseData;
    logic captureRd;
  } busStrobes_t;
endpackage

// File: rtl/rdyBusCtrl.sv
module rdyBusCtrl
  import rdyBusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgRdyEn,
  input  logic        reqValid,
  input  logic        busRdy,
  output logic        reqReady,
  output logic        doneOut,
  output busStrobes_t strobes
);
  busPhase_t phase, phaseNext;
  logic rdyFall;
  logic rdyOk;
  logic doneQ;

  // ready is sampled in the middle of each bus cycle
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rdyFall <= 1'b0;
    else       rdyFall <= busRdy;
  end

  assign rdyOk = !cfgRdyEn || rdyFall;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_ADDR;
      PH_ADDR: if (rdyOk)    phaseNext = PH_DATA;
      PH_DATA: if (rdyOk)    phaseNext = PH_IDLE;
      default:               phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= (phase == PH_DATA) && rdyOk;
    end
  end

  assign reqReady          = (phase == PH_IDLE);
  assign doneOut           = doneQ;
  assign strobes.loadReq   = (phase == PH_IDLE) && reqValid;
  assign strobes.phaseAddr = (phase == PH_ADDR);
  assign strobes.phaseData = (phase == PH_DATA);
  assign strobes.captureRd = (phase == PH_DATA) && rdyOk;
endmodule

// File: rtl/rdyBusDatapath.sv
module rdyBusDatapath
  import rdyBusPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [DATA_W-1:0] rdData,
  output logic              busFrame,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe
);
  logic              dirWrite;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirWrite <= 1'b0;
      addrQ    <= '0;
      wdataQ   <= '0;
    end else if (strobes.loadReq) begin
      dirWrite <= reqWrite;
      addrQ    <= reqAddr;
      wdataQ   <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                rdataQ <= '0;
    else if (strobes.captureRd && !dirWrite) rdataQ <= busDin;
  end

  assign active   = strobes.phaseAddr || strobes.phaseData;
  assign busFrame = strobes.phaseAddr;
  assign busRd    = strobes.phaseAddr && !dirWrite;
  assign busWr    = strobes.phaseAddr && dirWrite;
  assign busAddr  = active ? addrQ : '0;
  assign busDoe   = active && dirWrite;
  assign busDout  = wdataQ;
  assign rdData   = rdataQ;
endmodule

// File: rtl/rdyBusMaster.sv
module rdyBusMaster
  import rdyBusPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRdyEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              doneOut,
  output logic [DATA_W-1:0] rdData,
  output logic              busFrame,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busRdy
);
  busStrobes_t strobes;

  rdyBusCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgRdyEn (cfgRdyEn),
    .reqValid (reqValid),
    .busRdy   (busRdy),
    .reqReady (reqReady),
    .doneOut  (doneOut),
    .strobes  (strobes)
  );

  rdyBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busDin   (busDin),
    .rdData   (rdData),
    .busFrame (busFrame),
    .busRd    (busRd),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busDout  (busDout),
    .busDoe   (busDoe)
  );
endmodule

// File: rtl/rdyBusChk.sv
module rdyBusChk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgRdyEn,
  input logic              busRdy,
  input logic              reqReady,
  input logic              doneOut,
  input logic              busFrame,
  input logic              busRd,
  input logic              busWr,
  input logic              busDoe,
  input logic [ADDR_W-1:0] busAddr
);
  logic chkRdy;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) chkRdy <= 1'b0;
    else       chkRdy <= busRdy;
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    busFrame |-> (busRd ^ busWr));

  p_no_strobe_outside_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busFrame |-> (!busRd && !busWr));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busFrame && cfgRdyEn && !chkRdy) |=> (busFrame && $stable(busAddr)));

  p_two_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busFrame && !cfgRdyEn) |=> !busFrame);

  p_doe_write_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> !busRd);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    busFrame |-> !reqReady);
endmodule

bind rdyBusMaster rdyBusChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cfgRdyEn (cfgRdyEn),
  .busRdy   (busRdy),
  .reqReady (reqReady),
  .doneOut  (doneOut),
  .busFrame (busFrame),
  .busRd    (busRd),
  .busWr    (busWr),
  .busDoe   (busDoe),
  .busAddr  (busAddr)
);

// File: tb/rdyBusMaster_tb.sv
`timescale 1ns/1ps
module rdyBusMaster_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgRdyEn = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, doneOut, busFrame, busRd, busWr, busDoe;
  logic [DW-1:0] rdData, busDout;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDin = '0;
  logic busRdy = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rdyBusMaster #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgRdyEn(cfgRdyEn),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .doneOut(doneOut), .rdData(rdData),
    .busFrame(busFrame), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busDout(busDout), .busDoe(busDoe), .busDin(busDin), .busRdy(busRdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // outputs packed as {frame, rd, wr, doe, reqReady, doneOut}
  function automatic logic [5:0] ctl();
    return {busFrame, busRd, busWr, busDoe, reqReady, doneOut};
  endfunction

  task automatic runAccess(input bit wr, input int sa, input int sd, input bit en, input int idx);
    logic [AW-1:0] a = AW'(idx * 37 + 5);
    logic [DW-1:0] wd = DW'(idx * 11 + 3);
    logic [DW-1:0] rd = DW'(idx * 29 + 17);
    int effA = en ? sa : 0;
    int effD = en ? sd : 0;
    cfgRdyEn = en;
    chk("R1 idle ready", reqReady, 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; busRdy = 1'b1;
    step();
    reqValid = 1'b0;
    for (int i = 0; i <= effA; i++) begin
      busRdy = (i < sa) ? 1'b0 : 1'b1;
      chk("R2/R4 addr phase ctl", ctl(), {1'b1, !wr, wr, wr, 1'b0, 1'b0});
      chk("R2/R4 addr phase addr", busAddr, a);
      if (wr) chk("R8 write data addr phase", busDout, wd);
      step();
    end
    for (int i = 0; i <= effD; i++) begin
      busRdy = (i < sd) ? 1'b0 : 1'b1;
      busDin = (i == effD) ? rd : ~rd;
      chk("R3/R5 data phase ctl", ctl(), {1'b0, 1'b0, 1'b0, wr, 1'b0, 1'b0});
      chk("R3/R5 data phase addr", busAddr, a);
      if (wr) chk("R8 write data data phase", busDout, wd);
      if (i == 0 && effD > 0) begin
        // R1: a request while busy must not disturb the access
        reqValid = 1'b1; reqAddr = ~a;
      end else begin
        reqValid = 1'b0;
      end
      step();
    end
    reqValid = 1'b0;
    busRdy = 1'b1;
    chk("R9 done after data phase", ctl(), 6'b000011);
    chk("R10 idle addr zero", busAddr, 0);
    if (!wr) chk("R6 read capture", rdData, rd);
    step();
    chk("R9 done one cycle", doneOut, 0);
    chk("R1 no spurious access", busFrame, 0);
  endtask

  initial begin
    #3;
    chk("R10 reset ctl", ctl(), 6'b000010);
    chk("R10 reset addr", busAddr, 0);
    step();
    rstN = 1'b1;
    step();
    chk("R10 after reset ctl", ctl(), 6'b000010);
    begin
      int idx = 0;
      for (int en = 0; en < 2; en++)
        for (int w = 0; w < 2; w++)
          for (int sa = 0; sa < 4; sa++)
            for (int sd = 0; sd < 4; sd++) begin
              runAccess(w[0], sa, sd, en[0], idx);
              idx++;
            end
    end
    // R7: ready held low throughout with stretching disabled
    cfgRdyEn = 1'b0;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 8'hA5; busRdy = 1'b0;
    step();
    reqValid = 1'b0;
    chk("R7 addr phase one cycle", busFrame, 1);
    step();
    busDin = 8'h3C;
    chk("R7 data phase one cycle", ctl(), 6'b000000);
    step();
    chk("R7 done despite low ready", doneOut, 1);
    chk("R7 read data", rdData, 8'h3C);
    busRdy = 1'b1;
    step();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule